// File: doc/BRIEF.md
# Programmable Near-Empty / Near-Full Status Flag Unit

This block produces the two level flags of a 1024-word FIFO from its word count. It does not hold the storage or the pointers; the FIFO supplies its occupancy in words, including the word held in the output register, so the count runs from 0 to 1025. It drives two outputs. The half flag reports more than half occupancy. The band flag is a single output that is high whenever the FIFO is close to empty or close to full. One offset, X, sets the width of both bands.

The offset is loaded from the low nine data bits on a falling edge of the define strobe. The strobe is sampled in the write-clock domain. A new offset does not take effect at once. The threshold register loads only while reset is asserted, so the value in force is the one selected in the last reset cycle. If the strobe is low at that point, the stored offset is used. If it is high, the built-in default of 256 is used. Keeping the strobe low through later resets keeps the same offset. Both flags are registered and follow the occupancy one clock later.

Top module: `lvlflag_gen`

## Requirements
- R1: While reset is asserted, each clock edge drives the band flag high and the half flag low, whatever the occupancy.
- R2: One clock after an occupancy of 513 or more is presented, the half flag is high. For 512 or fewer it is low.
- R3: One clock after an occupancy of X+1 or fewer is presented, the band flag is high.
- R4: One clock after an occupancy of 1025−X or more is presented, the band flag is high. For an occupancy from X+2 to 1024−X inclusive it is low.
- R5: A falling edge of the define strobe (sampled high on one clock, low on the next) stores the 9-bit offset input as X. Changes of the offset input while the strobe stays low store nothing.
- R6: If the strobe is low in the last cycle of reset, the thresholds after release use the stored X.
- R7: If the strobe is high in the last cycle of reset, the thresholds after release use X = 256.
- R8: Once out of reset, the thresholds do not move. This holds even when a new offset is stored, until the next reset.
- R9: If the strobe is held low across a further reset with no new falling edge, the same X stays in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| def_strobe | input | 1 | Define strobe; a falling edge stores the offset |
| ofs_data | input | 9 | Offset value, taken from the low nine data bits |
| occupancy | input | 11 | FIFO word count, 0 to 1025 |
| half_flag | output | 1 | High at 513 or more words |
| band_flag | output | 1 | High near empty or near full |

## Verification
The bench steps the occupancy across each band edge: X+1 against X+2, 1024−X against 1025−X, and 512 against 513. It does this for X = 0, 37, 256, 300 and 511, so a comparator that is off by one flips the flag one word early or late. It stores a new offset in mid-operation and checks that the thresholds stay fixed until the next reset. It also moves the offset input while the strobe stays low and checks that nothing is stored, so a design that latches on the strobe level picks up the wrong X. Finally, it resets with the strobe high after an offset has been stored, which catches a design that ignores the default selection and keeps the stored X.

// File: rtl/lvlflag_pkg.sv
package lvlflag_pkg;
    typedef struct packed {
        logic half;
        logic band;
    } flag_t;
endpackage

// File: rtl/lvl_ofs_capture.sv
module lvl_ofs_capture #(
    parameter int OFS_W = 9
) (
    input  logic             clk,
    input  logic             def_strobe,
    input  logic [OFS_W-1:0] ofs_data,
    output logic [OFS_W-1:0] ofs_now
);
    typedef struct packed {
        logic             strobe;
        logic [OFS_W-1:0] ofs;
    } cap_t;

    cap_t cap_d, cap_q;
    logic fall;

    // Offset storage survives reset on purpose: it must persist across resets.
    always_comb begin
        cap_d        = cap_q;
        fall         = cap_q.strobe & ~def_strobe;
        cap_d.strobe = def_strobe;
        if (fall)
            cap_d.ofs = ofs_data;
        ofs_now = fall ? ofs_data : cap_q.ofs;
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end
endmodule

// File: rtl/lvl_band_compare.sv
module lvl_band_compare #(
    parameter int DEPTH = 1024,
    parameter int OFS_W = 9,
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0] occupancy,
    input  logic [OFS_W-1:0] thr,
    output logic             half_hit,
    output logic             band_hit
);
    localparam int CMP_W = CNT_W + 2;
    localparam logic [CMP_W-1:0] HALF_MARK = CMP_W'(DEPTH / 2 + 1);
    localparam logic [CMP_W-1:0] TOP_BASE  = CMP_W'(DEPTH + 1);

    logic [CMP_W-1:0] occ_w, low_edge, high_edge;

    always_comb begin
        occ_w     = CMP_W'(occupancy);
        low_edge  = CMP_W'(thr) + CMP_W'(1);
        high_edge = TOP_BASE - CMP_W'(thr);
        half_hit  = occ_w >= HALF_MARK;
        band_hit  = (occ_w <= low_edge) || (occ_w >= high_edge);
    end
endmodule

// File: rtl/lvlflag_gen.sv
module lvlflag_gen #(
    parameter int DEPTH       = 1024,
    parameter int OFS_W       = 9,
    parameter int DEFAULT_OFS = 256,
    parameter int CNT_W       = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             def_strobe,
    input  logic [OFS_W-1:0] ofs_data,
    input  logic [CNT_W-1:0] occupancy,
    output logic             half_flag,
    output logic             band_flag
);
    import lvlflag_pkg::*;

    localparam logic [OFS_W-1:0] DEF_THR = OFS_W'(DEFAULT_OFS);

    typedef struct packed {
        flag_t            flags;
        logic [OFS_W-1:0] thr;
    } st_t;

    st_t              st_d, st_q;
    logic [OFS_W-1:0] ofs_now;
    logic [OFS_W-1:0] thr_cur;
    logic             half_hit, band_hit;

    lvl_ofs_capture #(.OFS_W(OFS_W)) u_cap (
        .clk        (clk),
        .def_strobe (def_strobe),
        .ofs_data   (ofs_data),
        .ofs_now    (ofs_now)
    );

    lvl_band_compare #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cmp (
        .occupancy (occupancy),
        .thr       (st_q.thr),
        .half_hit  (half_hit),
        .band_hit  (band_hit)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.flags.half = 1'b0;
            st_d.flags.band = 1'b1;
            st_d.thr        = def_strobe ? DEF_THR : ofs_now;
        end else begin
            st_d.flags.half = half_hit;
            st_d.flags.band = band_hit;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign thr_cur   = st_q.thr;
    assign half_flag = st_q.flags.half;
    assign band_flag = st_q.flags.band;
endmodule

// File: rtl/lvlflag_chk.sv
module lvlflag_chk #(
    parameter int DEPTH       = 1024,
    parameter int OFS_W       = 9,
    parameter int DEFAULT_OFS = 256,
    parameter int CNT_W       = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             def_strobe,
    input logic [CNT_W-1:0] occupancy,
    input logic             half_flag,
    input logic             band_flag,
    input logic [OFS_W-1:0] thr_cur
);
    logic seen_q = 1'b0;
    logic prev_rst_n_q = 1'b1;

    always_ff @(posedge clk) begin
        seen_q       <= 1'b1;
        prev_rst_n_q <= rst_n;
        if (seen_q && !prev_rst_n_q) begin
            a_r1_reset_flags: assert (band_flag && !half_flag)
                else $error("reset flag state wrong");
        end
    end

    a_r2_half_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (half_flag == (int'($past(occupancy)) >= DEPTH / 2 + 1)));

    a_r4_band_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (band_flag ==
            ((int'($past(occupancy)) <= int'(thr_cur) + 1) ||
             (int'($past(occupancy)) >= DEPTH + 1 - int'(thr_cur)))));

    a_r8_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(thr_cur));

    a_r7_default_pick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && $past(def_strobe)) |-> (int'(thr_cur) == DEFAULT_OFS));
endmodule

bind lvlflag_gen lvlflag_chk #(
    .DEPTH(DEPTH), .OFS_W(OFS_W), .DEFAULT_OFS(DEFAULT_OFS), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .def_strobe (def_strobe),
    .occupancy  (occupancy),
    .half_flag  (half_flag),
    .band_flag  (band_flag),
    .thr_cur    (thr_cur)
);

// File: tb/lvlflag_gen_tb.sv
module lvlflag_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        def_strobe = 1'b1;
    logic [8:0]  ofs_data = '0;
    logic [10:0] occupancy = '0;
    logic        half_flag, band_flag;
    int          nchk = 0;
    int          nfail = 0;
    int          act_x = 256;
    int          stored_x = 0;

    always #4 clk = ~clk;

    lvlflag_gen u_dut (
        .clk(clk), .rst_n(rst_n), .def_strobe(def_strobe), .ofs_data(ofs_data),
        .occupancy(occupancy), .half_flag(half_flag), .band_flag(band_flag)
    );

    function automatic bit exp_half(int o);
        return o >= 513;
    endfunction

    function automatic bit exp_band(int o, int x);
        return (o <= x + 1) || (o >= 1025 - x);
    endfunction

    task automatic chk(bit got, bit exp, string tag);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0b expected %0b (occupancy %0d, X %0d)",
                     tag, got, exp, occupancy, act_x);
        end
    endtask

    task automatic apply(int o, string tagb);
        @(negedge clk) occupancy = 11'(o);
        @(posedge clk); #1;
        chk(half_flag, exp_half(o), "R2 half flag");
        chk(band_flag, exp_band(o, act_x), tagb);
    endtask

    task automatic sweep(string tagb);
        int pts[8];
        pts = '{0, act_x + 1, act_x + 2, 512, 513, 1024 - act_x, 1025 - act_x, 1025};
        foreach (pts[i]) apply(pts[i], tagb);
    endtask

    // Only call with level 0 when the strobe is already low (no new edge).
    task automatic do_reset(bit level);
        @(negedge clk) begin
            def_strobe = level;
            rst_n      = 1'b0;
            occupancy  = 11'd700;
        end
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk(band_flag, 1'b1, "R1 band in reset");
            chk(half_flag, 1'b0, "R1 half in reset");
        end
        @(negedge clk) rst_n = 1'b1;
        act_x = level ? 256 : stored_x;
    endtask

    task automatic program_x(int v);
        @(negedge clk) def_strobe = 1'b1;
        @(negedge clk) begin
            ofs_data   = 9'(v);
            def_strobe = 1'b0;
        end
        stored_x = v;
        @(posedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset(1'b1);
        sweep("R7 default X band");              // R7, R3, R4
        program_x(37);
        sweep("R8 thresholds held after new X"); // R8
        do_reset(1'b0);
        sweep("R6 stored X band");               // R6, R3, R4
        @(negedge clk) ofs_data = 9'd400;        // R5: level change, no edge
        do_reset(1'b0);
        sweep("R9 R5 X kept across reset");
        program_x(0);
        do_reset(1'b0);
        sweep("R3 R4 X=0 edges");
        program_x(511);
        do_reset(1'b0);
        sweep("R3 R4 X=511 edges");
        do_reset(1'b1);
        sweep("R7 default over stored X");
        program_x(300);
        do_reset(1'b0);
        sweep("R5 R6 X=300 edges");
        for (int r = 0; r < 8; r++) begin
            int v;
            v = int'($urandom_range(0, 511));
            program_x(v);
            do_reset(1'($urandom_range(0, 1)));
            for (int k = 0; k < 400; k++)
                apply(int'($urandom_range(0, 1025)), "R3 R4 random band");
        end
        report();
    end
endmodule